// File: doc/BRIEF.md
# Serial-Bus PHY Control and Interrupt Register Unit

This block holds the software-visible control and status state of a serial-bus physical-layer device. It keeps the node fields that are copied into the self-identification packet: link-active, contender and power class. It also keeps a request bit for a short arbitrated bus reset and four sticky event flags: configuration time-out, cable-power drop, state time-out and port event. Each field has its own response to a hardware reset and to a bus reset. Software reaches the fields through a small synchronous register port. Writes take effect on the clock edge, and reads return data combinationally from the address.

When the link layer is powered down, the block must still be able to get its attention. If the interrupt enable is set and a configuration time-out, cable-power or state time-out flag is pending while the link-power-status input is low, a small state machine raises a link-on request. The machine has two states. LK_QUIET is the reset state, with no request. LK_SIGNAL drives the request. The transition LK_QUIET to LK_SIGNAL happens on the clock after the wake condition becomes true. The transition LK_SIGNAL to LK_QUIET happens on the clock after the condition goes false. Hardware reset forces LK_QUIET.

The cable-power level is asynchronous. It passes through a two-flop synchronizer, and a falling edge is detected on the synchronized value.

Top module: `phy_ctl_regs`

## Requirements
- R1: After a hardware reset (`hw_rst` high, synchronous), the fields take these values: link control = 1, contender = `contender_strap`, power class = 000, interrupt enable = 0, short-reset request = 0, configuration time-out, state time-out and port-event flags = 0, and the cable-power flag = 1.
- R2: `sid_link_active` is high only while both `lps_in` and the link-control bit are high.
- R3: A bus reset leaves link control, contender, power class and interrupt enable unchanged.
- R4: Address 0 is read/write, with link control at bit 0, contender at bit 1 and power class at bits 4:2. Bits 7:5 form the repeater-jitter field, which always reads 0 and ignores writes. The contender and power class also appear on `sid_contender` and `sid_pwr`.
- R5: Address 1 bit 1 is the short-reset request, shown on `short_rst_req`. Writing it sets or clears it. A bus reset clears it, and the bus reset wins over a write in the same cycle.
- R6: Address 1 holds the sticky flags: bit 2 configuration time-out, bit 3 cable power, bit 4 state time-out, bit 5 port event. A flag sets on its event. Writing 1 to a flag bit clears it, and writing 0 has no effect.
- R7: If a set event and a write-1-to-clear reach the same flag in the same cycle, the flag stays set.
- R8: The cable-power flag sets on the third clock edge after `cable_pwr_in` falls, and never on a rise.
- R9: Address 1 bit 0 is the interrupt enable. A `resume_evt` pulse sets the port-event flag (`port_evt`) only while this enable is 1.
- R10: `link_on` rises one clock after this condition becomes true: `lps_in` low, the enable set, and the configuration time-out, cable-power or state time-out flag set. It falls one clock after the condition goes false. The port-event flag does not take part.
- R11: Reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| bus_rst | input | 1 | One-cycle bus-reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| lps_in | input | 1 | Link-power-status level |
| contender_strap | input | 1 | Contender value loaded at hardware reset |
| cable_pwr_in | input | 1 | Asynchronous cable-power level |
| cfg_timeout_evt | input | 1 | Configuration time-out event pulse |
| state_timeout_evt | input | 1 | State time-out event pulse |
| resume_evt | input | 1 | Port resume start pulse |
| sid_link_active | output | 1 | Self-ID link-active flag |
| sid_contender | output | 1 | Self-ID contender flag |
| sid_pwr | output | 3 | Self-ID power class |
| short_rst_req | output | 1 | Short bus-reset request |
| port_evt | output | 1 | Port-event flag |
| link_on | output | 1 | Link-on notification |

## Verification
The hardest situation to reach is a set event and a write-1-to-clear arriving at the same flag in the same cycle. A close second is a bus reset that lands in the same cycle as a write of the short-reset request. The directed tasks put the event pulse and the write strobe in the same clock period, and likewise the bus-reset pulse and the write. They then read the register back to see which side won. The link-on path is driven through every transition: a flag becoming pending while the link is down, the link coming up, the link dropping again with the flag still pending, and the enable being cleared. The cable-power case counts clock edges after the falling level to confirm the synchronizer delay.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;
    // address 0 layout
    localparam int NODE_LINK_BIT = 0;
    localparam int NODE_CONT_BIT = 1;
    localparam int NODE_PWR_LSB  = 2;
    localparam int PWR_W         = 3;
    // address 1 layout
    localparam int IRQ_EN_BIT    = 0;
    localparam int IRQ_SRST_BIT  = 1;
    localparam int IRQ_FLAG_LSB  = 2;
    // sticky flag indices, contiguous from IRQ_FLAG_LSB
    localparam int FLG_CFG = 0;
    localparam int FLG_CBL = 1;
    localparam int FLG_STO = 2;
    localparam int FLG_PEV = 3;
    localparam int NFLAG   = 4;
    localparam logic [NFLAG-1:0] FLAG_RST_VAL = 4'b0010;
    localparam int ADDR_NODE = 0;
    localparam int ADDR_IRQ  = 1;

    typedef enum logic {
        LK_QUIET  = 1'b0,
        LK_SIGNAL = 1'b1
    } lk_state_e;
endpackage

// File: rtl/phy_cps_edge.sv
module phy_cps_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic fall_pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], level_in};
        end
    end

    // chain_q[SYNC_STAGES-1] is the synchronized level, chain_q[SYNC_STAGES] its previous value
    assign fall_pulse = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/phy_sticky_bit.sv
module phy_sticky_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_w1,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= RST_VAL;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_w1) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_linkon_fsm.sv
module phy_linkon_fsm
    import phy_regs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wake_cond,
    output logic link_on
);
    lk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_QUIET:  if (wake_cond)  state_d = LK_SIGNAL;
            LK_SIGNAL: if (!wake_cond) state_d = LK_QUIET;
            default:   state_d = LK_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LK_SIGNAL: link_on = 1'b1;
            default:   link_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
    import phy_regs_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              hw_rst,
    input  logic              bus_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              lps_in,
    input  logic              contender_strap,
    input  logic              cable_pwr_in,
    input  logic              cfg_timeout_evt,
    input  logic              state_timeout_evt,
    input  logic              resume_evt,
    output logic              sid_link_active,
    output logic              sid_contender,
    output logic [2:0]        sid_pwr,
    output logic              short_rst_req,
    output logic              port_evt,
    output logic              link_on
);
    localparam logic [ADDR_W-1:0] A_NODE = ADDR_W'(ADDR_NODE);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(ADDR_IRQ);

    logic             link_ctl_q;
    logic             cont_q;
    logic [PWR_W-1:0] pwr_q;
    logic             irq_en_q;
    logic             srst_q;
    logic             wr_node, wr_irq;
    logic             cps_fall;
    logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
    logic             wake;
    logic             unused_wbits;

    assign wr_node = reg_wr && (reg_addr == A_NODE);
    assign wr_irq  = reg_wr && (reg_addr == A_IRQ);
    assign unused_wbits = ^reg_wdata[DATA_W-1:5];

    // node fields: untouched by bus reset
    always_ff @(posedge clk) begin
        if (hw_rst) begin
            link_ctl_q <= 1'b1;
            cont_q     <= contender_strap;
            pwr_q      <= '0;
            irq_en_q   <= 1'b0;
        end else begin
            if (wr_node) begin
                link_ctl_q <= reg_wdata[NODE_LINK_BIT];
                cont_q     <= reg_wdata[NODE_CONT_BIT];
                pwr_q      <= reg_wdata[NODE_PWR_LSB +: PWR_W];
            end
            if (wr_irq) begin
                irq_en_q <= reg_wdata[IRQ_EN_BIT];
            end
        end
    end

    // short-reset request: bus reset has priority over a write
    always_ff @(posedge clk) begin
        if (hw_rst) begin
            srst_q <= 1'b0;
        end else if (bus_rst) begin
            srst_q <= 1'b0;
        end else if (wr_irq) begin
            srst_q <= reg_wdata[IRQ_SRST_BIT];
        end
    end

    phy_cps_edge #(.SYNC_STAGES(2)) cps_i (
        .clk        (clk),
        .rst        (hw_rst),
        .level_in   (cable_pwr_in),
        .fall_pulse (cps_fall)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_CFG] = cfg_timeout_evt;
        flag_set[FLG_CBL] = cps_fall;
        flag_set[FLG_STO] = state_timeout_evt;
        flag_set[FLG_PEV] = resume_evt & irq_en_q;
    end

    assign flag_clr = {NFLAG{wr_irq}} & reg_wdata[IRQ_FLAG_LSB +: NFLAG];

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        phy_sticky_bit #(.RST_VAL(FLAG_RST_VAL[g])) flag_i (
            .clk     (clk),
            .rst     (hw_rst),
            .set_evt (flag_set[g]),
            .clr_w1  (flag_clr[g]),
            .flag_q  (flag_q[g])
        );
    end

    assign wake = !lps_in && irq_en_q &&
                  (flag_q[FLG_CFG] || flag_q[FLG_CBL] || flag_q[FLG_STO]);

    phy_linkon_fsm lk_i (
        .clk       (clk),
        .rst       (hw_rst),
        .wake_cond (wake),
        .link_on   (link_on)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_NODE) begin
            reg_rdata[NODE_LINK_BIT]              = link_ctl_q;
            reg_rdata[NODE_CONT_BIT]              = cont_q;
            reg_rdata[NODE_PWR_LSB +: PWR_W]      = pwr_q;
        end else if (reg_addr == A_IRQ) begin
            reg_rdata[IRQ_EN_BIT]                 = irq_en_q;
            reg_rdata[IRQ_SRST_BIT]               = srst_q;
            reg_rdata[IRQ_FLAG_LSB +: NFLAG]      = flag_q;
        end
    end

    assign sid_link_active = lps_in & link_ctl_q;
    assign sid_contender   = cont_q;
    assign sid_pwr         = pwr_q;
    assign short_rst_req   = srst_q;
    assign port_evt        = flag_q[FLG_PEV];
endmodule

// File: rtl/phy_ctl_regs_chk.sv
module phy_ctl_regs_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              hw_rst,
    input logic              bus_rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              lps_in,
    input logic              resume_evt,
    input logic              sid_link_active,
    input logic              sid_contender,
    input logic [2:0]        sid_pwr,
    input logic              short_rst_req,
    input logic              port_evt,
    input logic              link_on
);
    p_link_active_r2: assert property (@(posedge clk) disable iff (hw_rst)
        !lps_in |-> !sid_link_active);

    p_node_keep_r3: assert property (@(posedge clk) disable iff (hw_rst)
        (bus_rst && !(reg_wr && reg_addr == ADDR_W'(0))) |=> ($stable(sid_contender) && $stable(sid_pwr)));

    p_jitter_zero_r4: assert property (@(posedge clk) disable iff (hw_rst)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[7:5] == 3'b000));

    p_short_clr_r5: assert property (@(posedge clk) disable iff (hw_rst)
        bus_rst |=> !short_rst_req);

    p_pev_hold_r6: assert property (@(posedge clk) disable iff (hw_rst)
        (port_evt && !(reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[5])) |=> port_evt);

    p_pev_cause_r9: assert property (@(posedge clk) disable iff (hw_rst)
        $rose(port_evt) |-> $past(resume_evt));

    p_linkon_idle_r10: assert property (@(posedge clk) disable iff (hw_rst)
        link_on |-> !$past(lps_in));

    p_unused_addr_r11: assert property (@(posedge clk) disable iff (hw_rst)
        (reg_addr > ADDR_W'(1)) |-> (reg_rdata == '0));
endmodule

bind phy_ctl_regs phy_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/phy_ctl_regs_tb_top.sv
`timescale 1ns/100ps
module phy_ctl_regs_tb_top;
    logic       clk = 1'b0;
    logic       hw_rst = 1'b1;
    logic       bus_rst = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       lps_in = 1'b1;
    logic       contender_strap = 1'b1;
    logic       cable_pwr_in = 1'b1;
    logic       cfg_timeout_evt = 1'b0;
    logic       state_timeout_evt = 1'b0;
    logic       resume_evt = 1'b0;
    logic       sid_link_active, sid_contender, short_rst_req, port_evt, link_on;
    logic [2:0] sid_pwr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phy_ctl_regs dut_i (.*);

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #0.2;
        chk(req, int'(reg_rdata), int'(exp));
    endtask

    task automatic t_reset;
        hw_rst = 1'b1;
        step(2);
        hw_rst = 1'b0;
        step();
        rd_chk(2'd0, 8'h03, "R1 node reset");
        rd_chk(2'd1, 8'h08, "R1 irq reset");
        chk("R1 contender", int'(sid_contender), 1);
        chk("R1 pwr", int'(sid_pwr), 0);
        chk("R1 short", int'(short_rst_req), 0);
        chk("R1 port_evt", int'(port_evt), 0);
        chk("R1 link_on", int'(link_on), 0);
    endtask

    task automatic t_link_active;
        chk("R2 both high", int'(sid_link_active), 1);
        lps_in = 1'b0;
        #0.2;
        chk("R2 lps low", int'(sid_link_active), 0);
        lps_in = 1'b1;
        wr(2'd0, 8'h02);
        chk("R2 ctl low", int'(sid_link_active), 0);
        wr(2'd0, 8'h03);
        chk("R2 restored", int'(sid_link_active), 1);
    endtask

    task automatic t_node_write;
        wr(2'd0, 8'hFF);
        rd_chk(2'd0, 8'h1F, "R4 jitter reads 0");
        chk("R4 sid_pwr", int'(sid_pwr), 7);
        wr(2'd0, 8'h15);
        rd_chk(2'd0, 8'h15, "R4 node readback");
        chk("R4 sid_contender", int'(sid_contender), 0);
        chk("R4 sid_pwr 5", int'(sid_pwr), 5);
    endtask

    task automatic t_bus_reset;
        wr(2'd1, 8'h03);
        rd_chk(2'd1, 8'h0B, "R5 short set");
        chk("R5 short out", int'(short_rst_req), 1);
        bus_rst = 1'b1;
        step();
        bus_rst = 1'b0;
        chk("R5 short cleared", int'(short_rst_req), 0);
        rd_chk(2'd1, 8'h09, "R3 enable kept");
        rd_chk(2'd0, 8'h15, "R3 node kept");
        // write and bus reset in the same cycle: bus reset wins
        bus_rst = 1'b1;
        wr(2'd1, 8'h03);
        bus_rst = 1'b0;
        chk("R5 bus reset wins", int'(short_rst_req), 0);
    endtask

    task automatic t_sticky;
        wr(2'd1, 8'h09);
        rd_chk(2'd1, 8'h01, "R6 cable cleared");
        cfg_timeout_evt = 1'b1; step(); cfg_timeout_evt = 1'b0;
        rd_chk(2'd1, 8'h05, "R6 cfg set");
        wr(2'd1, 8'h01);
        rd_chk(2'd1, 8'h05, "R6 write 0 no effect");
        wr(2'd1, 8'h05);
        rd_chk(2'd1, 8'h01, "R6 cfg w1c");
        state_timeout_evt = 1'b1; step(); state_timeout_evt = 1'b0;
        rd_chk(2'd1, 8'h11, "R6 state set");
        state_timeout_evt = 1'b1;
        wr(2'd1, 8'h11);
        state_timeout_evt = 1'b0;
        rd_chk(2'd1, 8'h11, "R7 set beats clear");
        wr(2'd1, 8'h11);
        rd_chk(2'd1, 8'h01, "R6 state w1c");
    endtask

    task automatic t_cable;
        cable_pwr_in = 1'b0;
        step(2);
        rd_chk(2'd1, 8'h01, "R8 not yet after 2 edges");
        step();
        rd_chk(2'd1, 8'h09, "R8 set after 3 edges");
        cable_pwr_in = 1'b1;
        wr(2'd1, 8'h09);
        step(5);
        rd_chk(2'd1, 8'h01, "R8 rise ignored");
    endtask

    task automatic t_port_evt;
        wr(2'd1, 8'h00);
        resume_evt = 1'b1; step(); resume_evt = 1'b0;
        chk("R9 gated off", int'(port_evt), 0);
        wr(2'd1, 8'h01);
        resume_evt = 1'b1; step(); resume_evt = 1'b0;
        chk("R9 enabled set", int'(port_evt), 1);
        wr(2'd1, 8'h21);
        chk("R9 w1c", int'(port_evt), 0);
    endtask

    task automatic t_linkon;
        lps_in = 1'b0;
        step(2);
        chk("R10 no flag", int'(link_on), 0);
        resume_evt = 1'b1; step(); resume_evt = 1'b0;
        step();
        chk("R10 port flag excluded", int'(link_on), 0);
        wr(2'd1, 8'h21);
        cfg_timeout_evt = 1'b1; step(); cfg_timeout_evt = 1'b0;
        chk("R10 not same cycle", int'(link_on), 0);
        step();
        chk("R10 raised", int'(link_on), 1);
        lps_in = 1'b1;
        step();
        chk("R10 link up drops", int'(link_on), 0);
        lps_in = 1'b0;
        step();
        chk("R10 link down pending", int'(link_on), 1);
        wr(2'd1, 8'h00);
        chk("R10 one cycle lag", int'(link_on), 1);
        step();
        chk("R10 enable off", int'(link_on), 0);
        wr(2'd1, 8'h05);
        lps_in = 1'b1;
        rd_chk(2'd1, 8'h01, "R10 cleanup");
    endtask

    task automatic t_unused;
        rd_chk(2'd2, 8'h00, "R11 addr2");
        rd_chk(2'd3, 8'h00, "R11 addr3");
    endtask

    initial begin
        #1;
        t_reset();
        t_link_active();
        t_node_write();
        t_bus_reset();
        t_sticky();
        t_cable();
        t_port_evt();
        t_linkon();
        t_unused();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule